// File: doc/BRIEF.md
# Window-Regulated Switching Controller

This block sequences the two power switches of an inductor DC/DC converter from a handful of digital flags. Each switching cycle has two parts. In the charge part the main switch is on for an on-time counted in clock ticks. In the discharge part the synchronous rectifier is on until an inductor zero-current flag arrives, or until a fixed tick limit runs out. A one-tick dead gap separates the two parts. A second dead gap follows the discharge part, and on that gap the controller reads the two window comparator flags, above-high and below-low, and settles the on-time for the next cycle.

While the output stays inside the window, the on-time does not change. An above-high event trims the on-time by one tick. A below-low event adds a large step to it. The on-time saturates at 1 and at its maximum. The controller drops into pulse-frequency mode after a run of above-high decisions taken at the minimum on-time. In that mode it keeps the on-time it has learned and fires one pulse each time the output falls below the high limit. A below-low event returns it to fixed-pattern cycling. In that fixed-pattern mode each charge part starts on a rising edge of the synchronisation input.

A shutdown input parks both gates low. The up/down select decides which physical switch does the charging. It is captured only while the block is shut down.

Top module: `window_sw_ctrl`

## Requirements
- R1: While rst_ni is low both gates are low. The first charge pulse after reset lasts TON_RST ticks (default 8).
- R2: A cycle whose decision sees neither window flag leaves the next charge pulse the same length as the last one. A charge pulse lasts exactly the on-time in ticks.
- R3: In fixed-pattern mode, an above-high flag at the decision (with below-low clear) shortens the next charge pulse by 1 tick. The pulse never goes below 1 tick.
- R4: A below-low flag at the decision lengthens the next charge pulse by STEP_UP ticks (default 8). The pulse never goes above 2^TON_W-1 (63). Below-low wins when both flags are set.
- R5: After PFM_HITS (default 4) consecutive decisions in fixed-pattern mode with above-high set and the on-time at 1, the block enters pulse-frequency mode. In that mode sync edges start no charge pulse.
- R6: In pulse-frequency mode no charge pulse starts while above-high is high. A pulse starts the tick after above-high drops, with the learned on-time, and above-high at the decision does not alter the on-time.
- R7: A below-low flag in pulse-frequency mode, at the decision or while idle, returns the block to fixed-pattern mode with the on-time raised by STEP_UP.
- R8: The rectifier gate falls on the tick after zero_cur_i is seen high during discharge. If zero_cur_i never comes, the rectifier gate stays on for TOFF ticks.
- R9: hs_gate_o and ls_gate_o are never high together. Exactly one tick with both low lies between the end of a charge pulse and the start of the rectifier pulse, and after the rectifier pulse.
- R10: With shdn_i high, both gates are low from the next tick onward and no switching occurs. A pulse in progress is abandoned without a decision.
- R11: buck_i=1 puts the charge pulse on hs_gate_o and the rectifier on ls_gate_o. buck_i=0 swaps them. buck_i is captured only while shut down or in reset, and a change during switching has no effect.
- R12: In fixed-pattern mode, a charge pulse begins on the tick after a rising edge of sync_i, once the previous cycle has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | control clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| buck_i | input | 1 | 1 = step-down, 0 = step-up switch mapping |
| shdn_i | input | 1 | stop all switching while high |
| sync_i | input | 1 | cycle start clock for fixed-pattern mode |
| above_hi_i | input | 1 | output above the high window limit |
| below_lo_i | input | 1 | output below the low window limit |
| zero_cur_i | input | 1 | inductor current has reached zero |
| hs_gate_o | output | 1 | high-side switch gate |
| ls_gate_o | output | 1 | low-side switch gate |

## Verification
The bench builds the controller with TON_W=6, TON_RST=8, STEP_UP=8, PFM_HITS=4, SYNC_EN=1 and TOFF=12. With a short TOFF, the discharge timeout is reached by a zero-current flag that arrives late. A reset value of 8 means seven trimming cycles bring the on-time to its floor, so entry into pulse-frequency mode is reached early in the run. From there, eight below-low steps reach the 63-tick ceiling within the same run.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  typedef enum logic [2:0] {
    PH_OFF,
    PH_WAIT,
    PH_IDLE,
    PH_CHG,
    PH_DT1,
    PH_DIS,
    PH_DT2
  } phase_e;
endpackage

// File: rtl/wsc_ontime.sv
module wsc_ontime #(
  parameter int TON_W    = 6,
  parameter int TON_MIN  = 1,
  parameter int TON_RST  = 8,
  parameter int STEP_UP  = 8,
  parameter int PFM_HITS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dec_i,
  input  logic             hi_i,
  input  logic             lo_i,
  input  logic             idle_lo_i,
  output logic [TON_W-1:0] ton_o,
  output logic             pfm_o
);
  localparam int TON_MAX = (1 << TON_W) - 1;
  localparam int HIT_W   = $clog2(PFM_HITS + 1);

  logic [TON_W-1:0] ton_q, ton_d, ton_up, ton_dn;
  logic [TON_W:0]   up_sum;
  logic [HIT_W-1:0] hits_q, hits_d;
  logic             pfm_q, pfm_d, raise;

  assign up_sum = {1'b0, ton_q} + (TON_W+1)'(STEP_UP);
  assign ton_up = (up_sum > (TON_W+1)'(TON_MAX)) ? TON_W'(TON_MAX) : up_sum[TON_W-1:0];
  assign ton_dn = (ton_q > TON_W'(TON_MIN)) ? ton_q - TON_W'(1) : TON_W'(TON_MIN);
  assign raise  = (dec_i && lo_i) || idle_lo_i;

  always_comb begin
    ton_d  = ton_q;
    pfm_d  = pfm_q;
    hits_d = hits_q;
    if (raise) begin
      ton_d  = ton_up;
      pfm_d  = 1'b0;
      hits_d = '0;
    end else if (dec_i && !pfm_q) begin
      if (hi_i) begin
        ton_d = ton_dn;
        if (ton_q == TON_W'(TON_MIN)) begin
          if (hits_q == HIT_W'(PFM_HITS - 1)) begin
            pfm_d  = 1'b1;
            hits_d = '0;
          end else begin
            hits_d = hits_q + HIT_W'(1);
          end
        end else begin
          hits_d = '0;
        end
      end else begin
        hits_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ton_q  <= TON_W'(TON_RST);
      pfm_q  <= 1'b0;
      hits_q <= '0;
    end else begin
      ton_q  <= ton_d;
      pfm_q  <= pfm_d;
      hits_q <= hits_d;
    end
  end

  assign ton_o = ton_q;
  assign pfm_o = pfm_q;

  assert_ton_floor_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ton_q >= TON_W'(TON_MIN));
  assert_step_down_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && hi_i && !lo_i && !pfm_q && ton_q > TON_W'(TON_MIN))
    |=> ton_q == $past(ton_q) - TON_W'(1));
  assert_step_up_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && lo_i && {1'b0, ton_q} <= (TON_W+1)'(TON_MAX - STEP_UP))
    |=> ton_q == $past(ton_q) + TON_W'(STEP_UP));
  assert_hold_in_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !hi_i && !lo_i && !idle_lo_i) |=> $stable(ton_q));
  assert_pfm_entry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pfm_q) |-> $past(dec_i && hi_i && ton_q == TON_W'(TON_MIN)));
  assert_pfm_exit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pfm_q && idle_lo_i) |=> !pfm_q);
endmodule

// File: rtl/wsc_phase.sv
module wsc_phase
  import wsc_pkg::*;
#(
  parameter int TON_W   = 6,
  parameter int TOFF    = 32,
  parameter int SYNC_EN = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shdn_i,
  input  logic             sync_i,
  input  logic             hi_i,
  input  logic             lo_i,
  input  logic             zero_i,
  input  logic             pfm_i,
  input  logic [TON_W-1:0] ton_i,
  output logic             charge_o,
  output logic             dischg_o,
  output logic             dec_o,
  output logic             idle_lo_o,
  output logic             off_o
);
  localparam int OFF_W = $clog2(TOFF + 1);
  localparam int CNT_W = (TON_W > OFF_W) ? TON_W : OFF_W;

  phase_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sync_go;

  generate
    if (SYNC_EN != 0) begin : g_sync
      logic sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= 1'b0;
        else         sync_q <= sync_i;
      end
      assign sync_go = sync_i && !sync_q;
    end else begin : g_free
      assign sync_go = 1'b1;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + CNT_W'(1);
    if (shdn_i) begin
      state_d = PH_OFF;
    end else begin
      unique case (state_q)
        PH_OFF:  state_d = pfm_i ? PH_IDLE : PH_WAIT;
        PH_WAIT: begin
          if (pfm_i) state_d = PH_IDLE;
          else if (sync_go) begin
            state_d = PH_CHG;
            cnt_d   = CNT_W'(1);
          end
        end
        PH_IDLE: begin
          if (lo_i || !hi_i) begin
            state_d = PH_CHG;
            cnt_d   = CNT_W'(1);
          end
        end
        PH_CHG:  if (cnt_q == CNT_W'(ton_i)) state_d = PH_DT1;
        PH_DT1: begin
          state_d = PH_DIS;
          cnt_d   = CNT_W'(1);
        end
        PH_DIS:  if (zero_i || cnt_q == CNT_W'(TOFF)) state_d = PH_DT2;
        PH_DT2:  state_d = PH_WAIT;
        default: state_d = PH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign charge_o  = (state_q == PH_CHG);
  assign dischg_o  = (state_q == PH_DIS);
  assign off_o     = (state_q == PH_OFF);
  assign dec_o     = (state_q == PH_DT2) && !shdn_i;
  assign idle_lo_o = (state_q == PH_IDLE) && lo_i && !shdn_i;

  assert_dead_after_charge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(charge_o) |-> !dischg_o);
  assert_dead_before_dischg_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dischg_o) |-> $past(state_q == PH_DT1));
  assert_zero_ends_dischg_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_DIS && zero_i && !shdn_i) |=> !dischg_o);
  assert_pfm_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pfm_i && state_q == PH_IDLE && hi_i && !lo_i && !shdn_i) |=> !charge_o);
  assert_sync_start_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_WAIT && !pfm_i && sync_go && !shdn_i) |=> charge_o);
endmodule

// File: rtl/wsc_gate_map.sv
module wsc_gate_map (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic off_i,
  input  logic buck_i,
  input  logic charge_i,
  input  logic dischg_i,
  output logic hs_o,
  output logic ls_o
);
  logic buck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    buck_q <= 1'b0;
    else if (off_i) buck_q <= buck_i;
  end

  assign hs_o = buck_q ? charge_i : dischg_i;
  assign ls_o = buck_q ? dischg_i : charge_i;

  assert_mode_latched_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !off_i |=> $stable(buck_q));
  assert_gates_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_o && ls_o));
endmodule

// File: rtl/window_sw_ctrl.sv
module window_sw_ctrl #(
  parameter int TON_W    = 6,
  parameter int TON_MIN  = 1,
  parameter int TON_RST  = 8,
  parameter int STEP_UP  = 8,
  parameter int PFM_HITS = 4,
  parameter int TOFF     = 32,
  parameter int SYNC_EN  = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic buck_i,
  input  logic shdn_i,
  input  logic sync_i,
  input  logic above_hi_i,
  input  logic below_lo_i,
  input  logic zero_cur_i,
  output logic hs_gate_o,
  output logic ls_gate_o
);
  logic [TON_W-1:0] ton;
  logic pfm, dec, idle_lo, charge, dischg, off;

  wsc_ontime #(
    .TON_W(TON_W), .TON_MIN(TON_MIN), .TON_RST(TON_RST),
    .STEP_UP(STEP_UP), .PFM_HITS(PFM_HITS)
  ) u_ontime (
    .clk_i(clk_i), .rst_ni(rst_ni), .dec_i(dec), .hi_i(above_hi_i),
    .lo_i(below_lo_i), .idle_lo_i(idle_lo), .ton_o(ton), .pfm_o(pfm)
  );

  wsc_phase #(.TON_W(TON_W), .TOFF(TOFF), .SYNC_EN(SYNC_EN)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .shdn_i(shdn_i), .sync_i(sync_i),
    .hi_i(above_hi_i), .lo_i(below_lo_i), .zero_i(zero_cur_i), .pfm_i(pfm),
    .ton_i(ton), .charge_o(charge), .dischg_o(dischg), .dec_o(dec),
    .idle_lo_o(idle_lo), .off_o(off)
  );

  wsc_gate_map u_map (
    .clk_i(clk_i), .rst_ni(rst_ni), .off_i(off), .buck_i(buck_i),
    .charge_i(charge), .dischg_i(dischg), .hs_o(hs_gate_o), .ls_o(ls_gate_o)
  );

  assert_shutdown_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shdn_i |=> (!hs_gate_o && !ls_gate_o));
endmodule

// File: tb/window_sw_ctrl_test.sv
`timescale 1ns/1ps
module window_sw_ctrl_test;
  localparam int TOFF = 12;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic buck_i = 1'b0, shdn_i = 1'b0, sync_i = 1'b0;
  logic above_hi_i = 1'b0, below_lo_i = 1'b0, zero_cur_i = 1'b0;
  logic hs_gate_o, ls_gate_o;

  int  n_vec = 0, n_bad = 0;
  bit  done = 0;
  int  exp_ton = 8, exp_hits = 0;
  bit  exp_pfm = 0, exp_buck = 0;

  always #10 clk = ~clk;

  window_sw_ctrl #(.TON_W(6), .TON_MIN(1), .TON_RST(8), .STEP_UP(8),
                   .PFM_HITS(4), .TOFF(TOFF), .SYNC_EN(1)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .buck_i(buck_i), .shdn_i(shdn_i),
    .sync_i(sync_i), .above_hi_i(above_hi_i), .below_lo_i(below_lo_i),
    .zero_cur_i(zero_cur_i), .hs_gate_o(hs_gate_o), .ls_gate_o(ls_gate_o)
  );

  function automatic logic chg_g();
    return exp_buck ? hs_gate_o : ls_gate_o;
  endfunction
  function automatic logic rec_g();
    return exp_buck ? ls_gate_o : hs_gate_o;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_dec(bit hi, bit lo);
    if (lo) begin
      exp_ton  = (exp_ton + 8 > 63) ? 63 : exp_ton + 8;
      exp_pfm  = 0;
      exp_hits = 0;
    end else if (!exp_pfm) begin
      if (hi) begin
        if (exp_ton == 1) begin
          exp_hits++;
          if (exp_hits == 4) begin exp_pfm = 1; exp_hits = 0; end
        end else exp_hits = 0;
        exp_ton = (exp_ton > 1) ? exp_ton - 1 : 1;
      end else exp_hits = 0;
    end
  endtask

  task automatic run_cycle(bit hi, bit lo, int d, string lbl);
    int w, r, want;
    bit was_pfm;
    want = exp_ton;
    was_pfm = exp_pfm;
    @(negedge clk);
    if (exp_pfm) above_hi_i = 1'b0; else sync_i = 1'b1;
    @(negedge clk);
    sync_i = 1'b0;
    chk(was_pfm ? "R6" : "R12", chg_g(), 1);
    chk("R11", rec_g(), 0);
    w = 0;
    while (chg_g() && w < 80) begin
      w++;
      @(negedge clk);
    end
    chk(lbl, w, want);
    chk("R9", rec_g(), 0);
    @(negedge clk);
    chk("R9", rec_g(), 1);
    above_hi_i = hi;
    below_lo_i = lo;
    r = 1;
    if (d == 1) zero_cur_i = 1'b1;
    while (rec_g() && r < 80) begin
      @(negedge clk);
      if (rec_g()) begin
        r++;
        if (r == d) zero_cur_i = 1'b1;
      end
    end
    zero_cur_i = 1'b0;
    chk("R8", r, (d < TOFF) ? d : TOFF);
    chk("R9", chg_g(), 0);
    @(negedge clk);
    model_dec(hi, lo);
    below_lo_i = 1'b0;
    above_hi_i = exp_pfm;
  endtask

  task automatic pfm_hold(string lbl);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      sync_i = i[0];
      chk(lbl, hs_gate_o | ls_gate_o, 0);
    end
    sync_i = 1'b0;
  endtask

  task automatic abort_with_shdn(bit nb);
    @(negedge clk); sync_i = 1'b1;
    @(negedge clk); sync_i = 1'b0;
    chk("R12", chg_g(), 1);
    @(negedge clk); shdn_i = 1'b1; buck_i = nb;
    @(negedge clk);
    chk("R10", hs_gate_o | ls_gate_o, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      sync_i = ~sync_i;
      chk("R10", hs_gate_o | ls_gate_o, 0);
    end
    sync_i = 1'b0;
    shdn_i = 1'b0;
    exp_buck = nb;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", hs_gate_o | ls_gate_o, 0);
    rst_ni = 1'b1;
    run_cycle(0, 0, 4, "R1");
    run_cycle(0, 0, TOFF + 5, "R2");
    run_cycle(1, 0, 3, "R2");
    repeat (10) run_cycle(1, 0, 3, "R3");
    chk("R5", exp_pfm, 1);
    pfm_hold("R5");
    run_cycle(1, 0, 5, "R6");
    pfm_hold("R6");
    run_cycle(0, 0, 5, "R6");
    run_cycle(0, 1, 5, "R6");
    run_cycle(0, 0, 5, "R7");
    repeat (8) run_cycle(0, 1, 2, "R4");
    run_cycle(1, 1, 2, "R4");
    run_cycle(1, 0, 2, "R4");
    run_cycle(0, 0, 2, "R2");
    abort_with_shdn(1'b1);
    run_cycle(0, 0, 3, "R11");
    buck_i = 1'b0;
    run_cycle(0, 0, 3, "R11");
    abort_with_shdn(1'b0);
    run_cycle(0, 0, 3, "R11");
    for (int i = 0; i < 250; i++) begin
      bit hi, lo;
      hi = ($urandom % 100) < 45;
      lo = ($urandom % 100) < 12;
      run_cycle(hi, lo, 1 + int'($urandom % (TOFF + 4)), "R2");
      if (exp_pfm && ($urandom % 4 == 0)) pfm_hold("R6");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule